// File: doc/BRIEF.md
# Partial-Access Integer Register File

This block holds eight 32-bit integer registers. Each one can be reached as a whole word, as its low 16-bit half, or as a single byte. There is one write port and two read ports. Every port carries a 3-bit register index, a 2-bit size code and a high-byte select. The index order is: 0 accumulator, 1 base, 2 count, 3 data, 4 source index, 5 destination index, 6 base pointer, 7 stack pointer. A narrow write changes only the bits it names, and the rest of the register keeps its old contents. A narrow read returns the selected field, zero-extended to 32 bits.

Only indices 0 to 3 have a second byte view, at bits 15:8. A high-byte write to any other register is dropped, and `wr_err` rises for one cycle. Size code 11 is reserved and is handled the same way. Both read ports are combinational and show the stored contents from before any write in the same cycle. Writes are stored on the rising clock edge.

Top module: `subword_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released, all eight registers read as zero and `wr_err` is low until a new write occurs.
- R2: Size code 10 (word) with `wr_en` high stores all 32 bits of `wr_data` on the rising edge. When `wr_en` is low, no register changes and `wr_err` stays low.
- R3: Size code 01 (half) stores `wr_data[15:0]` into bits 15:0 and keeps bits 31:16. The high-byte select has no effect at this size.
- R4: Size code 00 (byte) stores `wr_data[7:0]` into bits 7:0 when the high-byte select is 0, and into bits 15:8 when it is 1. All other bits keep their values.
- R5: A byte write with the high-byte select set and an index of 4 or more changes no register. `wr_err` is then high for exactly the one cycle after that clock edge.
- R6: A write with size code 11 changes no register and pulses `wr_err` for one cycle, as in R5. A read with size code 11 returns zero.
- R7: Reads are combinational. Word returns the full register. Half returns bits 15:0 with bits 31:16 at zero. Byte returns bits 7:0, or bits 15:8 when the high-byte select is 1, in the low byte of the output with all bits above it at zero. A high-byte read of index 4 or more returns zero.
- R8: A read of the register being written in the same cycle returns the old value. The new value appears after the rising edge.
- R9: A write changes only the register it indexes. The two read ports work independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write size code: 00 byte, 01 half, 10 word, 11 reserved |
| wr_hi | input | 1 | Write high-byte select (bits 15:8) |
| wr_data | input | 32 | Write data, low-aligned for narrow sizes |
| ra_idx | input | 3 | Read port A register index |
| ra_size | input | 2 | Read port A size code |
| ra_hi | input | 1 | Read port A high-byte select |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_idx | input | 3 | Read port B register index |
| rb_size | input | 2 | Read port B size code |
| rb_hi | input | 1 | Read port B high-byte select |
| rb_data | output | 32 | Read port B data, zero-extended |
| wr_err | output | 1 | One-cycle pulse after a dropped illegal write |

## Verification
The bench writes a mix of word, half and byte data into the same register. It then reads both the narrow field and the full word, so a merge that clears or sign-fills the untouched bits shows up at once as a wrong full word. High-byte writes to an index of 4 or more, and writes with the reserved size, are aimed at registers that already hold known data. A design that leaked such a write would change that data, and one that failed to pulse the error would leave `wr_err` low. The bench also checks that a high-byte read of an upper register returns zero, and that the half size ignores the high-byte select. A same-cycle read and write of one register is sampled before the edge, so a design with a write bypass returns the new value too early.

// File: rtl/srf_pkg.sv
package srf_pkg;

  // access size codes shared by write and read ports
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  localparam int LANE_W = 8;

endpackage

// File: rtl/srf_rst_sync.sv
module srf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/srf_wr_decode.sv
module srf_wr_decode
  import srf_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int XLEN        = 32,
  parameter int HIBYTE_REGS = 4,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int LANES = XLEN / LANE_W
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  input  logic             hi,
  input  logic [XLEN-1:0]  data,
  output logic [LANES-1:0] lane_mask,
  output logic [XLEN-1:0]  lane_data,
  output logic             illegal
);

  localparam logic [IDX_W:0] HB_LIM = (IDX_W+1)'(HIBYTE_REGS);

  logic hb_ok;

  always_comb begin
    hb_ok = ({1'b0, idx} < HB_LIM);
  end

  always_comb begin
    lane_mask = '0;
    lane_data = data;
    illegal   = 1'b0;
    case (acc_size_e'(size))
      SZ_BYTE: begin
        lane_data = {LANES{data[LANE_W-1:0]}};
        if (hi) begin
          if (hb_ok) begin
            lane_mask[1] = 1'b1;
          end else begin
            illegal = 1'b1;
          end
        end else begin
          lane_mask[0] = 1'b1;
        end
      end
      SZ_HALF: begin
        lane_data    = {(LANES/2){data[2*LANE_W-1:0]}};
        lane_mask[1:0] = 2'b11;
      end
      SZ_WORD: begin
        lane_mask = '1;
      end
      default: begin
        illegal = 1'b1;
      end
    endcase
  end

  // a dropped write never enables a lane
  always_comb begin
    if (illegal) begin
      assert_no_lane_on_illegal_R5: assert (lane_mask == '0);
    end
  end

endmodule

// File: rtl/srf_store.sv
module srf_store
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int XLEN     = 32,
  localparam int LANES = XLEN / LANE_W
) (
  input  logic                              clk,
  input  logic                              rst_q_n,
  input  logic [NUM_REGS-1:0][LANES-1:0]    we_mask,
  input  logic [XLEN-1:0]                   wdata,
  output logic [NUM_REGS-1:0][XLEN-1:0]     q_all
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      logic [LANE_W-1:0] lane_d;
      logic              lane_ce;

      always_comb begin
        lane_ce = we_mask[r][l];
        lane_d  = wdata[l*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n) begin
          lane_q <= '0;
        end else if (lane_ce) begin
          lane_q <= lane_d;
        end
      end

      assign q_all[r][l*LANE_W +: LANE_W] = lane_q;
    end
  end

endmodule

// File: rtl/srf_rd_extract.sv
module srf_rd_extract
  import srf_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int XLEN        = 32,
  parameter int HIBYTE_REGS = 4,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][XLEN-1:0] regs,
  input  logic [IDX_W-1:0]              idx,
  input  logic [1:0]                    size,
  input  logic                          hi,
  output logic [XLEN-1:0]               data
);

  localparam logic [IDX_W:0] HB_LIM = (IDX_W+1)'(HIBYTE_REGS);

  logic [XLEN-1:0] sel;
  logic            hb_ok;

  always_comb begin
    sel   = regs[idx];
    hb_ok = ({1'b0, idx} < HB_LIM);
  end

  always_comb begin
    data = '0;
    case (acc_size_e'(size))
      SZ_BYTE: begin
        if (!hi) begin
          data[LANE_W-1:0] = sel[LANE_W-1:0];
        end else if (hb_ok) begin
          data[LANE_W-1:0] = sel[2*LANE_W-1:LANE_W];
        end
      end
      SZ_HALF: begin
        data[2*LANE_W-1:0] = sel[2*LANE_W-1:0];
      end
      SZ_WORD: begin
        data = sel;
      end
      default: begin
        data = '0;
      end
    endcase
  end

  // narrow results carry no bits above their field
  always_comb begin
    if (size == 2'b00) begin
      assert_byte_zext_R7: assert (data[XLEN-1:LANE_W] == '0);
    end
    if (size == 2'b01) begin
      assert_half_zext_R7: assert (data[XLEN-1:2*LANE_W] == '0);
    end
    if (size == 2'b11) begin
      assert_rsvd_read_zero_R6: assert (data == '0);
    end
  end

endmodule

// File: rtl/subword_regfile.sv
module subword_regfile
  import srf_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int XLEN        = 32,
  parameter int HIBYTE_REGS = 4,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int LANES  = XLEN / LANE_W,
  localparam int NUM_RD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_size,
  input  logic             wr_hi,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [1:0]       ra_size,
  input  logic             ra_hi,
  output logic [XLEN-1:0]  ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [1:0]       rb_size,
  input  logic             rb_hi,
  output logic [XLEN-1:0]  rb_data,
  output logic             wr_err
);

  logic                          rst_q_n;
  logic [LANES-1:0]              lane_mask;
  logic [XLEN-1:0]               lane_data;
  logic                          wr_illegal;
  logic [NUM_REGS-1:0][LANES-1:0] we_mask;
  logic [NUM_REGS-1:0][XLEN-1:0] q_all;
  logic                          err_d;
  logic                          err_q;

  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx_v;
  logic [NUM_RD-1:0][1:0]        rd_size_v;
  logic [NUM_RD-1:0]             rd_hi_v;
  logic [NUM_RD-1:0][XLEN-1:0]   rd_data_v;

  srf_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  srf_wr_decode #(
    .NUM_REGS    (NUM_REGS),
    .XLEN        (XLEN),
    .HIBYTE_REGS (HIBYTE_REGS)
  ) u_wr_decode (
    .idx       (wr_idx),
    .size      (wr_size),
    .hi        (wr_hi),
    .data      (wr_data),
    .lane_mask (lane_mask),
    .lane_data (lane_data),
    .illegal   (wr_illegal)
  );

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      if (wr_en && !wr_illegal && (wr_idx == IDX_W'(r))) begin
        we_mask[r] = lane_mask;
      end else begin
        we_mask[r] = '0;
      end
    end
  end

  srf_store #(
    .NUM_REGS (NUM_REGS),
    .XLEN     (XLEN)
  ) u_store (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .we_mask (we_mask),
    .wdata   (lane_data),
    .q_all   (q_all)
  );

  // error pulse: next state then register
  always_comb begin
    err_d = wr_en & wr_illegal;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign wr_err = err_q;

  // read ports
  assign rd_idx_v  = {rb_idx, ra_idx};
  assign rd_size_v = {rb_size, ra_size};
  assign rd_hi_v   = {rb_hi, ra_hi};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    srf_rd_extract #(
      .NUM_REGS    (NUM_REGS),
      .XLEN        (XLEN),
      .HIBYTE_REGS (HIBYTE_REGS)
    ) u_rd (
      .regs (q_all),
      .idx  (rd_idx_v[p]),
      .size (rd_size_v[p]),
      .hi   (rd_hi_v[p]),
      .data (rd_data_v[p])
    );
  end

  assign ra_data = rd_data_v[0];
  assign rb_data = rd_data_v[1];

  // error follows a dropped write by one cycle
  assert_err_follows_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_err |-> $past(wr_en));

  assert_err_after_drop_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && (wr_size == 2'b11)) |=> wr_err);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
    assert_untargeted_stable_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
      !(wr_en && (wr_idx == IDX_W'(r))) |=> $stable(q_all[r]));

    assert_word_store_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en && (wr_idx == IDX_W'(r)) && (wr_size == 2'b10)) |=> (q_all[r] == $past(wr_data)));

    assert_half_keeps_top_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en && (wr_idx == IDX_W'(r)) && (wr_size == 2'b01))
        |=> ($stable(q_all[r][XLEN-1:16]) && (q_all[r][15:0] == $past(wr_data[15:0]))));

    assert_low_byte_merge_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en && (wr_idx == IDX_W'(r)) && (wr_size == 2'b00) && !wr_hi)
        |=> ($stable(q_all[r][XLEN-1:8]) && (q_all[r][7:0] == $past(wr_data[7:0]))));

    assert_high_byte_merge_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en && (wr_idx == IDX_W'(r)) && (wr_size == 2'b00) && wr_hi && (r < HIBYTE_REGS))
        |=> ($stable(q_all[r][XLEN-1:16]) && $stable(q_all[r][7:0])
             && (q_all[r][15:8] == $past(wr_data[7:0]))));

    assert_upper_hibyte_drop_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en && (wr_idx == IDX_W'(r)) && (wr_size == 2'b00) && wr_hi && (r >= HIBYTE_REGS))
        |=> ($stable(q_all[r]) && wr_err));
  end

endmodule

// File: tb/subword_regfile_tb.sv
module subword_regfile_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic        wen;
    logic [2:0]  widx;
    logic [1:0]  wsz;
    logic        whi;
    logic [31:0] wdata;
    logic [2:0]  aidx;
    logic [1:0]  asz;
    logic        ahi;
    logic [31:0] aexp;
    logic [2:0]  bidx;
    logic [31:0] bexp;
    logic        eexp;
    logic [3:0]  req;
  } vec_t;

  // size codes: 00 byte, 01 half, 10 word, 11 reserved
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd0, 2'b10, 1'b0, 32'h11223344, 3'd0, 2'b10, 1'b0, 32'h11223344, 3'd0, 32'h11223344, 1'b0, 4'd2}, // R2
    '{1'b1, 3'd0, 2'b01, 1'b0, 32'hAAAA5566, 3'd0, 2'b01, 1'b0, 32'h00005566, 3'd0, 32'h11225566, 1'b0, 4'd3}, // R3
    '{1'b1, 3'd0, 2'b00, 1'b0, 32'hFFFFFF77, 3'd0, 2'b00, 1'b0, 32'h00000077, 3'd0, 32'h11225577, 1'b0, 4'd4}, // R4
    '{1'b1, 3'd0, 2'b00, 1'b1, 32'h000000C3, 3'd0, 2'b00, 1'b1, 32'h000000C3, 3'd0, 32'h1122C377, 1'b0, 4'd4}, // R4
    '{1'b1, 3'd3, 2'b10, 1'b0, 32'hDEADBEEF, 3'd3, 2'b00, 1'b1, 32'h000000BE, 3'd3, 32'hDEADBEEF, 1'b0, 4'd7}, // R7
    '{1'b1, 3'd3, 2'b00, 1'b1, 32'h00000001, 3'd3, 2'b01, 1'b0, 32'h000001EF, 3'd3, 32'hDEAD01EF, 1'b0, 4'd4}, // R4
    '{1'b1, 3'd5, 2'b10, 1'b0, 32'hCAFEF00D, 3'd5, 2'b00, 1'b0, 32'h0000000D, 3'd5, 32'hCAFEF00D, 1'b0, 4'd7}, // R7
    '{1'b1, 3'd5, 2'b00, 1'b1, 32'h00000099, 3'd5, 2'b10, 1'b0, 32'hCAFEF00D, 3'd5, 32'hCAFEF00D, 1'b1, 4'd5}, // R5
    '{1'b1, 3'd5, 2'b00, 1'b0, 32'h00000042, 3'd5, 2'b00, 1'b0, 32'h00000042, 3'd5, 32'hCAFEF042, 1'b0, 4'd5}, // R5 pulse ends
    '{1'b1, 3'd7, 2'b11, 1'b0, 32'h12345678, 3'd7, 2'b11, 1'b0, 32'h00000000, 3'd7, 32'h00000000, 1'b1, 4'd6}, // R6
    '{1'b1, 3'd6, 2'b01, 1'b1, 32'h00009876, 3'd6, 2'b01, 1'b1, 32'h00009876, 3'd6, 32'h00009876, 1'b0, 4'd3}, // R3
    '{1'b0, 3'd1, 2'b10, 1'b0, 32'hFFFFFFFF, 3'd1, 2'b10, 1'b0, 32'h00000000, 3'd1, 32'h00000000, 1'b0, 4'd2}, // R2
    '{1'b1, 3'd4, 2'b00, 1'b0, 32'h000000AB, 3'd4, 2'b00, 1'b1, 32'h00000000, 3'd4, 32'h000000AB, 1'b0, 4'd7}, // R7
    '{1'b1, 3'd1, 2'b10, 1'b0, 32'h80808080, 3'd0, 2'b10, 1'b0, 32'h1122C377, 3'd1, 32'h80808080, 1'b0, 4'd9}  // R9
  };

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_size;
  logic        wr_hi;
  logic [31:0] wr_data;
  logic [2:0]  ra_idx;
  logic [1:0]  ra_size;
  logic        ra_hi;
  logic [31:0] ra_data;
  logic [2:0]  rb_idx;
  logic [1:0]  rb_size;
  logic        rb_hi;
  logic [31:0] rb_data;
  logic        wr_err;

  int total;
  int bad;

  subword_regfile u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_size (wr_size),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .ra_idx  (ra_idx),
    .ra_size (ra_size),
    .ra_hi   (ra_hi),
    .ra_data (ra_data),
    .rb_idx  (rb_idx),
    .rb_size (rb_size),
    .rb_hi   (rb_hi),
    .rb_data (rb_data),
    .wr_err  (wr_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    total   = 0;
    bad     = 0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_size = 2'b10;
    wr_hi   = 1'b0;
    wr_data = '0;
    ra_idx  = '0;
    ra_size = 2'b10;
    ra_hi   = 1'b0;
    rb_idx  = '0;
    rb_size = 2'b10;
    rb_hi   = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: every register reads zero after reset
    for (int i = 0; i < 8; i++) begin
      ra_idx = 3'(i);
      rb_idx = 3'(7 - i);
      #1;
      chk($sformatf("R1 reset reg%0d portA", i), ra_data, 32'h0);
      chk($sformatf("R1 reset reg%0d portB", 7 - i), rb_data, 32'h0);
    end
    chk("R1 reset wr_err", {31'b0, wr_err}, 32'h0);

    // table walk: write, then read both ports after the edge
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wr_en   = VECS[i].wen;
      wr_idx  = VECS[i].widx;
      wr_size = VECS[i].wsz;
      wr_hi   = VECS[i].whi;
      wr_data = VECS[i].wdata;
      @(negedge clk);
      wr_en   = 1'b0;
      ra_idx  = VECS[i].aidx;
      ra_size = VECS[i].asz;
      ra_hi   = VECS[i].ahi;
      rb_idx  = VECS[i].bidx;
      rb_size = 2'b10;
      rb_hi   = 1'b0;
      #1;
      chk($sformatf("R%0d vec%0d portA", VECS[i].req, i), ra_data, VECS[i].aexp);
      chk($sformatf("R%0d vec%0d portB word", VECS[i].req, i), rb_data, VECS[i].bexp);
      chk($sformatf("R%0d vec%0d wr_err", VECS[i].req, i), {31'b0, wr_err}, {31'b0, VECS[i].eexp});
    end

    // R8: same-cycle read of the written register shows the old value
    @(negedge clk);
    wr_en   = 1'b1;
    wr_idx  = 3'd2;
    wr_size = 2'b10;
    wr_hi   = 1'b0;
    wr_data = 32'h5A5A5A5A;
    ra_idx  = 3'd2;
    ra_size = 2'b10;
    ra_hi   = 1'b0;
    #1;
    chk("R8 read before edge", ra_data, 32'h00000000);
    @(posedge clk);
    #1;
    chk("R8 read after edge", ra_data, 32'h5A5A5A5A);
    @(negedge clk);
    wr_en = 1'b0;

    // R1: reset in mid-run clears stored data at once
    @(negedge clk);
    rst_n  = 1'b0;
    ra_idx = 3'd0;
    rb_idx = 3'd3;
    #1;
    chk("R1 mid-run reset portA", ra_data, 32'h0);
    chk("R1 mid-run reset portB", rb_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ra_idx = 3'd5;
    #1;
    chk("R1 after second reset", ra_data, 32'h0);
    chk("R1 after second reset wr_err", {31'b0, wr_err}, 32'h0);

    finish_run();
  end

endmodule